// File: doc/BRIEF.md
# Pointer Post-Modify Address Unit

This block generates data-memory addresses from a small bank of pointer registers. A 4-bit access field names one of four pointers and a post-modify code. While the access strobe is high, the block drives the chosen pointer's current value as the address. At the next clock edge it updates that pointer. The update can hold the pointer, step it by one or two, or add one of two signed increment registers.

Accesses come in two flavours. A plain access uses the primary modify encoding. The second phase of a two-step access uses a different encoding, selected by a phase input. Two bound registers give circular buffers: when the upper bound is non-zero and a pointer that equals it receives a +1 step, the pointer is reloaded from the lower bound. A short-immediate load port writes any of the eight registers. The increment registers are sign-extended on load and the others are zero-extended.

Top module: `ptr_modify_unit`

## Requirements
- R1: While `acc_en` is high, `addr_out` equals the value of the pointer selected by `acc_field[3:2]` (0 to 3 for pointers 0 to 3) before any modify, and `addr_valid` is high. The pointer update lands at the next rising clock edge.
- R2: With `acc_second` low, `acc_field[1:0]` selects the modify: 0 leaves the pointer unchanged, 1 adds 1, and 2 subtracts 1.
- R3: With `acc_second` low, code 3 adds the increment register J, taken as a signed 16-bit value.
- R4: With `acc_second` high, `acc_field[1:0]` selects the second-phase modify: 0 adds 1, 1 leaves the pointer unchanged, 2 adds 2, and 3 adds the signed increment register K.
- R5: When the upper bound register is non-zero, and a +1 modify (primary code 1 or second-phase code 0) hits a pointer equal to it, the pointer is loaded from the lower bound register instead.
- R6: The reload of R5 never happens on a −1, +2, +J or +K modify. It also never happens while the upper bound is zero.
- R7: An active-low reset clears all four pointers, J, K and both bound registers to zero.
- R8: When `imm_we` is high, `imm_val` (9 bits) is written at the next edge into the register named by `imm_sel`:
  - codes 0 to 3 select pointers 0 to 3;
  - code 4 selects J and code 5 selects K;
  - code 6 selects the lower bound and code 7 the upper bound.
  
  J and K take `imm_val` sign-extended from bit 8. All others take it zero-extended.
- R9: If an immediate write and an access target the same pointer in one cycle, the immediate value is stored and the modify is dropped.
- R10: A pointer changes only through an access or an immediate write, so it holds while `acc_en` and `imm_we` are low. All modify arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe |
| acc_second | input | 1 | Selects the second-phase modify encoding |
| acc_field | input | 4 | Pointer select [3:2] and modify code [1:0] |
| imm_we | input | 1 | Short-immediate write enable |
| imm_sel | input | 3 | Target register code for the immediate write |
| imm_val | input | 9 | Short-immediate value |
| addr_out | output | 16 | Pre-modify pointer value used as the address |
| addr_valid | output | 1 | Address qualifier, follows `acc_en` |

## Verification
The properties assume that the access field and phase input are stable and known for the whole cycle in which the strobe is high. They compare each pointer one edge later against the address shown in the access cycle. Most of them leave out cycles in which an immediate write targets the same pointer, because R9 gives that write priority.

The directed stimulus sets up each scenario through the immediate port. Every pointer update is then read back by a hold access, which does not change the value it shows. Values that a 9-bit immediate cannot reach, such as the top of the 16-bit range, are produced by adding a negative J.

// File: rtl/ptr_modify_pkg.sv
package ptr_modify_pkg;

   typedef enum logic [2:0] {
      STEP_HOLD = 3'd0,
      STEP_INC1 = 3'd1,
      STEP_DEC1 = 3'd2,
      STEP_INC2 = 3'd3,
      STEP_ADDJ = 3'd4,
      STEP_ADDK = 3'd5
   } step_e;

   function automatic step_e decode_step(input logic second, input logic [1:0] code);
      step_e s;
      if (!second) begin
         case (code)
            2'd0:    s = STEP_HOLD;
            2'd1:    s = STEP_INC1;
            2'd2:    s = STEP_DEC1;
            default: s = STEP_ADDJ;
         endcase
      end else begin
         case (code)
            2'd0:    s = STEP_INC1;
            2'd1:    s = STEP_HOLD;
            2'd2:    s = STEP_INC2;
            default: s = STEP_ADDK;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/ptr_step_decode.sv
module ptr_step_decode
   import ptr_modify_pkg::*;
(
   input  logic        second,
   input  logic [1:0]  code,
   output step_e       step
);

   always_comb begin
      step = decode_step(second, code);
   end

endmodule

// File: rtl/ptr_next_calc.sv
module ptr_next_calc
   import ptr_modify_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic [DATA_W-1:0] cur,
   input  step_e             step,
   input  logic [DATA_W-1:0] inc_j,
   input  logic [DATA_W-1:0] inc_k,
   input  logic [DATA_W-1:0] bound_lo,
   input  logic [DATA_W-1:0] bound_hi,
   output logic [DATA_W-1:0] nxt
);

   logic [DATA_W-1:0] stepped;

   always_comb begin
      case (step)
         STEP_INC1: stepped = cur + DATA_W'(1);
         STEP_DEC1: stepped = cur - DATA_W'(1);
         STEP_INC2: stepped = cur + DATA_W'(2);
         STEP_ADDJ: stepped = cur + inc_j;
         STEP_ADDK: stepped = cur + inc_k;
         default:   stepped = cur;
      endcase
   end

   generate
      if (WRAP_EN) begin : g_wrap
         logic hit;
         always_comb begin
            hit = (step == STEP_INC1) && (bound_hi != '0) && (cur == bound_hi);
            nxt = hit ? bound_lo : stepped;
         end
      end else begin : g_nowrap
         logic [2*DATA_W-1:0] unused_bounds;
         assign unused_bounds = {bound_lo, bound_hi};
         assign nxt = stepped;
      end
   endgenerate

endmodule

// File: rtl/ptr_imm_extend.sv
module ptr_imm_extend #(
   parameter int DATA_W = 16,
   parameter int IMM_W  = 9
) (
   input  logic [IMM_W-1:0]  imm,
   input  logic              sign_ext,
   output logic [DATA_W-1:0] word
);

   generate
      if (IMM_W == DATA_W) begin : g_full
         logic unused_sign;
         assign unused_sign = sign_ext;
         assign word = imm;
      end else begin : g_ext
         localparam int PAD_W = DATA_W - IMM_W;
         assign word = {{PAD_W{sign_ext & imm[IMM_W-1]}}, imm};
      end
   endgenerate

endmodule

// File: rtl/ptr_modify_unit.sv
module ptr_modify_unit
   import ptr_modify_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int NPTR    = 4,
   parameter int IMM_W   = 9,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        acc_en,
   input  logic                        acc_second,
   input  logic [$clog2(NPTR)+1:0]     acc_field,
   input  logic                        imm_we,
   input  logic [$clog2(NPTR+4)-1:0]   imm_sel,
   input  logic [IMM_W-1:0]            imm_val,
   output logic [DATA_W-1:0]           addr_out,
   output logic                        addr_valid
);

   localparam int PSEL_W  = $clog2(NPTR);
   localparam int FIELD_W = PSEL_W + 2;
   localparam int RSEL_W  = $clog2(NPTR + 4);
   localparam int J_CODE  = NPTR;
   localparam int K_CODE  = NPTR + 1;
   localparam int LO_CODE = NPTR + 2;
   localparam int HI_CODE = NPTR + 3;

   generate
      if (NPTR < 2 || (1 << PSEL_W) != NPTR) begin : g_bad_nptr
         $error("NPTR must be a power of two of at least 2");
      end
      if (IMM_W < 2 || IMM_W > DATA_W) begin : g_bad_imm
         $error("IMM_W must lie between 2 and DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] ptr_q [NPTR];
   logic [DATA_W-1:0] j_q, k_q, rb_q, re_q;
   logic [NPTR*DATA_W-1:0] ptr_flat;

   logic [PSEL_W-1:0] sel;
   logic [1:0]        code;
   logic [DATA_W-1:0] cur;
   logic [DATA_W-1:0] nxt;
   logic [DATA_W-1:0] imm_word;
   logic              imm_signed;
   step_e             step;

   assign sel  = acc_field[FIELD_W-1 -: PSEL_W];
   assign code = acc_field[1:0];
   assign cur  = ptr_q[sel];

   assign addr_out   = cur;
   assign addr_valid = acc_en;

   ptr_step_decode u_dec (
      .second (acc_second),
      .code   (code),
      .step   (step)
   );

   ptr_next_calc #(.DATA_W(DATA_W), .WRAP_EN(WRAP_EN)) u_calc (
      .cur      (cur),
      .step     (step),
      .inc_j    (j_q),
      .inc_k    (k_q),
      .bound_lo (rb_q),
      .bound_hi (re_q),
      .nxt      (nxt)
   );

   assign imm_signed = (imm_sel == RSEL_W'(J_CODE)) || (imm_sel == RSEL_W'(K_CODE));

   ptr_imm_extend #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
      .imm      (imm_val),
      .sign_ext (imm_signed),
      .word     (imm_word)
   );

   generate
      for (genvar p = 0; p < NPTR; p++) begin : g_ptr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ptr_q[p] <= '0;
            end else if (imm_we && imm_sel == RSEL_W'(p)) begin
               ptr_q[p] <= imm_word;
            end else if (acc_en && sel == PSEL_W'(p)) begin
               ptr_q[p] <= nxt;
            end
         end
         assign ptr_flat[p*DATA_W +: DATA_W] = ptr_q[p];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         j_q  <= '0;
         k_q  <= '0;
         rb_q <= '0;
         re_q <= '0;
      end else if (imm_we) begin
         if (imm_sel == RSEL_W'(J_CODE))  j_q  <= imm_word;
         if (imm_sel == RSEL_W'(K_CODE))  k_q  <= imm_word;
         if (imm_sel == RSEL_W'(LO_CODE)) rb_q <= imm_word;
         if (imm_sel == RSEL_W'(HI_CODE)) re_q <= imm_word;
      end
   end

endmodule

// File: rtl/ptr_modify_unit_chk.sv
module ptr_modify_unit_chk #(
   parameter int DATA_W  = 16,
   parameter int NPTR    = 4,
   parameter int IMM_W   = 9,
   parameter bit WRAP_EN = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        acc_en,
   input logic                        acc_second,
   input logic [$clog2(NPTR)+1:0]     acc_field,
   input logic                        imm_we,
   input logic [$clog2(NPTR+4)-1:0]   imm_sel,
   input logic [IMM_W-1:0]            imm_val,
   input logic [DATA_W-1:0]           addr_out,
   input logic                        addr_valid,
   input logic [NPTR*DATA_W-1:0]      ptr_flat,
   input logic [DATA_W-1:0]           j_q,
   input logic [DATA_W-1:0]           rb_q,
   input logic [DATA_W-1:0]           re_q
);

   localparam int PSEL_W  = $clog2(NPTR);
   localparam int FIELD_W = PSEL_W + 2;
   localparam int RSEL_W  = $clog2(NPTR + 4);

   logic [PSEL_W-1:0] sel;
   logic [1:0]        code;
   logic              imm_hit;
   logic              plus1;
   logic              wrap_c;
   logic              imm_ptr;

   assign sel     = acc_field[FIELD_W-1 -: PSEL_W];
   assign code    = acc_field[1:0];
   assign imm_hit = imm_we && (imm_sel == RSEL_W'(sel));
   assign plus1   = acc_second ? (code == 2'd0) : (code == 2'd1);
   assign wrap_c  = WRAP_EN && plus1 && (re_q != '0) && (addr_out == re_q);
   assign imm_ptr = imm_we && (imm_sel < RSEL_W'(NPTR));

   function automatic logic [DATA_W-1:0] pick(input logic [PSEL_W-1:0] s);
      return ptr_flat[int'(s)*DATA_W +: DATA_W];
   endfunction

   // R1
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en |-> addr_valid);

   // R2
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_second && code == 2'd0 && !imm_hit)
      |=> pick($past(sel)) == $past(addr_out));

   a_r2_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_second && code == 2'd1 && !imm_hit && !wrap_c)
      |=> pick($past(sel)) == $past(addr_out) + DATA_W'(1));

   a_r2_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_second && code == 2'd2 && !imm_hit)
      |=> pick($past(sel)) == $past(addr_out) - DATA_W'(1));

   // R3
   a_r3_add_j: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_second && code == 2'd3 && !imm_hit)
      |=> pick($past(sel)) == $past(addr_out) + $past(j_q));

   // R4
   a_r4_plus_two: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_second && code == 2'd2 && !imm_hit)
      |=> pick($past(sel)) == $past(addr_out) + DATA_W'(2));

   // R5
   a_r5_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && wrap_c && !imm_hit)
      |=> pick($past(sel)) == $past(rb_q));

   // R8
   a_r8_j_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (imm_we && imm_sel == RSEL_W'(NPTR) && imm_val[IMM_W-1])
      |=> (&j_q[DATA_W-1:IMM_W-1]));

   // R9
   a_r9_imm_wins: assert property (@(posedge clk) disable iff (!rst_n)
      imm_ptr |=> pick($past(imm_sel[PSEL_W-1:0])) == DATA_W'($past(imm_val)));

   // R10
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_en && !imm_we) |=> $stable(ptr_flat));

endmodule

bind ptr_modify_unit ptr_modify_unit_chk #(
   .DATA_W(DATA_W), .NPTR(NPTR), .IMM_W(IMM_W), .WRAP_EN(WRAP_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_second(acc_second),
   .acc_field(acc_field), .imm_we(imm_we), .imm_sel(imm_sel), .imm_val(imm_val),
   .addr_out(addr_out), .addr_valid(addr_valid), .ptr_flat(ptr_flat),
   .j_q(j_q), .rb_q(rb_q), .re_q(re_q)
);

// File: tb/ptr_modify_unit_test.sv
`timescale 1ns/1ps
module ptr_modify_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_second = 1'b0;
   logic [3:0]  acc_field = '0;
   logic        imm_we = 1'b0;
   logic [2:0]  imm_sel = '0;
   logic [8:0]  imm_val = '0;
   logic [15:0] addr_out;
   logic        addr_valid;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   ptr_modify_unit uut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_second(acc_second),
      .acc_field(acc_field), .imm_we(imm_we), .imm_sel(imm_sel), .imm_val(imm_val),
      .addr_out(addr_out), .addr_valid(addr_valid)
   );

   localparam logic [2:0] S_J = 3'd4, S_K = 3'd5, S_LO = 3'd6, S_HI = 3'd7;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   task automatic load(input logic [2:0] s, input logic [8:0] v);
      @(negedge clk);
      imm_we = 1'b1; imm_sel = s; imm_val = v;
      @(posedge clk); #1;
      imm_we = 1'b0;
   endtask

   task automatic access(input logic second, input logic [1:0] p, input logic [1:0] c,
                         input logic [15:0] exp_addr, input string tag);
      @(negedge clk);
      acc_en = 1'b1; acc_second = second; acc_field = {p, c};
      #1;
      chk({tag, " addr"}, addr_out, exp_addr);
      chk("R1 addr_valid", {15'd0, addr_valid}, 16'd1);
      @(posedge clk); #1;
      acc_en = 1'b0; acc_second = 1'b0;
   endtask

   task automatic peek(input logic [1:0] p, input logic [15:0] exp, input string tag);
      access(1'b0, p, 2'd0, exp, tag);
   endtask

   task automatic t_reset();
      for (int p = 0; p < 4; p++) peek(2'(p), 16'h0000, "R7 reset pointer");
      access(1'b0, 2'd0, 2'd3, 16'h0000, "R3 j zero at reset");
      peek(2'd0, 16'h0000, "R7 j reset zero");
      access(1'b1, 2'd1, 2'd3, 16'h0000, "R4 k zero at reset");
      peek(2'd1, 16'h0000, "R7 k reset zero");
      access(1'b0, 2'd2, 2'd1, 16'h0000, "R6 bounds zero");
      peek(2'd2, 16'h0001, "R7 R6 no wrap while upper bound zero");
   endtask

   task automatic t_primary();
      load(3'd1, 9'h010);
      access(1'b0, 2'd1, 2'd1, 16'h0010, "R2 inc");
      peek(2'd1, 16'h0011, "R2 after +1");
      access(1'b0, 2'd1, 2'd2, 16'h0011, "R2 dec");
      peek(2'd1, 16'h0010, "R2 after -1");
      peek(2'd1, 16'h0010, "R2 hold");
   endtask

   task automatic t_addj();
      load(S_J, 9'h1FD);
      load(3'd2, 9'h020);
      access(1'b0, 2'd2, 2'd3, 16'h0020, "R3 add negative j");
      peek(2'd2, 16'h001D, "R3 R8 j sign-extended");
      load(S_J, 9'h005);
      access(1'b0, 2'd2, 2'd3, 16'h001D, "R3 add positive j");
      peek(2'd2, 16'h0022, "R3 after +5");
   endtask

   task automatic t_second();
      load(3'd3, 9'h100);
      load(S_K, 9'h1FE);
      access(1'b1, 2'd3, 2'd0, 16'h0100, "R4 code0");
      peek(2'd3, 16'h0101, "R4 +1");
      access(1'b1, 2'd3, 2'd1, 16'h0101, "R4 code1");
      peek(2'd3, 16'h0101, "R4 hold");
      access(1'b1, 2'd3, 2'd2, 16'h0101, "R4 code2");
      peek(2'd3, 16'h0103, "R4 +2");
      access(1'b1, 2'd3, 2'd3, 16'h0103, "R4 code3");
      peek(2'd3, 16'h0101, "R4 +k negative");
   endtask

   task automatic t_wrap();
      load(S_LO, 9'h040);
      load(S_HI, 9'h043);
      load(3'd0, 9'h042);
      access(1'b0, 2'd0, 2'd1, 16'h0042, "R5 below bound");
      peek(2'd0, 16'h0043, "R5 normal +1");
      access(1'b0, 2'd0, 2'd1, 16'h0043, "R5 at bound");
      peek(2'd0, 16'h0040, "R5 primary wrap");
      load(3'd0, 9'h043);
      access(1'b1, 2'd0, 2'd0, 16'h0043, "R5 second at bound");
      peek(2'd0, 16'h0040, "R5 second-phase wrap");
      load(3'd0, 9'h043);
      access(1'b0, 2'd0, 2'd2, 16'h0043, "R6 dec at bound");
      peek(2'd0, 16'h0042, "R6 no wrap on -1");
      load(3'd0, 9'h043);
      load(S_J, 9'h001);
      access(1'b0, 2'd0, 2'd3, 16'h0043, "R6 +j at bound");
      peek(2'd0, 16'h0044, "R6 no wrap on +j");
      load(3'd0, 9'h043);
      access(1'b1, 2'd0, 2'd2, 16'h0043, "R6 +2 at bound");
      peek(2'd0, 16'h0045, "R6 no wrap on +2");
      load(S_HI, 9'h000);
      load(3'd0, 9'h000);
      access(1'b0, 2'd0, 2'd1, 16'h0000, "R6 disabled bound");
      peek(2'd0, 16'h0001, "R6 no wrap with upper bound zero");
   endtask

   task automatic t_extend();
      load(3'd1, 9'h1FF);
      peek(2'd1, 16'h01FF, "R8 pointer zero-extended");
      load(S_LO, 9'h1F0);
      load(S_HI, 9'h150);
      load(3'd1, 9'h150);
      access(1'b0, 2'd1, 2'd1, 16'h0150, "R8 at upper bound");
      peek(2'd1, 16'h01F0, "R8 bounds zero-extended");
      load(S_HI, 9'h000);
   endtask

   task automatic t_priority();
      load(3'd2, 9'h030);
      @(negedge clk);
      imm_we = 1'b1; imm_sel = 3'd2; imm_val = 9'h055;
      acc_en = 1'b1; acc_second = 1'b0; acc_field = {2'd2, 2'd1};
      #1;
      chk("R9 addr before write", addr_out, 16'h0030);
      @(posedge clk); #1;
      imm_we = 1'b0; acc_en = 1'b0;
      peek(2'd2, 16'h0055, "R9 immediate wins");
   endtask

   task automatic t_idle_modulo();
      load(3'd3, 9'h0AA);
      @(negedge clk);
      acc_en = 1'b0; acc_field = {2'd3, 2'd1};
      #1;
      chk("R1 addr_valid low when idle", {15'd0, addr_valid}, 16'd0);
      repeat (3) @(posedge clk);
      peek(2'd3, 16'h00AA, "R10 idle hold");
      load(3'd3, 9'h000);
      load(S_J, 9'h1FF);
      access(1'b0, 2'd3, 2'd3, 16'h0000, "R10 add -1 from zero");
      peek(2'd3, 16'hFFFF, "R10 underflow wrap");
      access(1'b0, 2'd3, 2'd1, 16'hFFFF, "R10 inc at top");
      peek(2'd3, 16'h0000, "R10 overflow wrap");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_primary();
      t_addj();
      t_second();
      t_wrap();
      t_extend();
      t_priority();
      t_idle_modulo();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule